// File: doc/BRIEF.md
# Counter CSR Access Permission Checker

This block sits beside the CSR file of a processor core and judges, combinationally, whether an access to a given 12-bit CSR address is allowed at the current effective privilege level. It also holds the counter-enable register, which machine-mode software writes to let user-mode code read the counter CSRs. A denied access is reported on `access_ok`. The trap raised for a denied access is handled elsewhere, as are the counters.

The counter-enable register is kept as a single storage bit. A write folds the implemented enable positions into that bit with an OR. A read copies the bit back onto every implemented position. Counter access from user mode is therefore granted for all counters together or denied for all counters together. The presence of user mode, of the base counters, of the performance counters and of debug support is given on static configuration pins. The block has no data stream, so every pin is a plain level signal.

Top module: `csr_perm_gate`

## Requirements
- R1: After reset, the enable bit is clear, and a read of the counter-enable register (address 0x306) returns all zeros.
- R2: When both counter types exist, an accepted write sets the enable bit exactly when any of write-data bits 15:0 is one. Bits 31:16 have no effect.
- R3: With only base counters, the bit stored is the OR of write-data bits 2:0. With only performance counters, it is the OR of bits 15:3.
- R4: When the register is read, bits 2:0 show the enable bit if base counters exist, bits 15:3 show it if performance counters exist, and every other bit is zero. A read of any other address returns zero.
- R5: Without user mode, the enable bit stays zero and writes have no effect. The register can still be accessed from machine mode.
- R6: In user mode with user mode implemented, an address whose bits 11:8 equal 0xC is denied when the enable bit is clear and at least one counter type exists. It is allowed when the bit is set, or when no counter type exists.
- R7: In machine mode, counter addresses (bits 11:8 equal to 0xC) are always allowed.
- R8: The debug-only addresses 0x7B0, 0x7B1 and 0x7B2 are denied when debug support exists and debug mode is not active. They are allowed when debug mode is active, or when debug support is absent.
- R9: In user mode, any address with bits 9:8 nonzero is denied. User-mode addresses with bits 9:8 equal to 00 and outside the counter range are allowed.
- R10: A write changes the register only when `csr_wr_en` is high, the address is 0x306 and `access_ok` is high. Any other write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_user_mode | input | 1 | User mode implemented |
| cfg_base_cnt | input | 1 | Base counters implemented |
| cfg_perf_cnt | input | 1 | Performance counters implemented |
| cfg_debug_sup | input | 1 | Debug mode supported |
| dbg_active | input | 1 | Core is currently in debug mode |
| priv_mach | input | 1 | Effective privilege: 1 = machine, 0 = user |
| csr_addr | input | 12 | CSR address of the current access |
| csr_wr_en | input | 1 | Write strobe for the current access |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data of the counter-enable register, zero for other addresses |
| access_ok | output | 1 | Access allowed |

## Verification
The decision logic is driven from a vector table that varies privilege, configuration, debug state and enable state across the counter, debug, machine-only and plain user address regions. This separates the three denial rules from each other and from their priority order. Directed writes place single ones below, inside and above each folded bit range under each counter configuration. These show whether the OR covers the right slice and whether the read copy lands on the right positions. Denied writes, writes to other addresses and the configuration without user mode confirm that the stored bit holds where it must.

// File: rtl/csr_perm_pkg.sv
package csr_perm_pkg;

  localparam int CSR_AW = 12;

  typedef enum logic {
    PRIV_USER = 1'b0,
    PRIV_MACH = 1'b1
  } priv_e;

  typedef struct packed {
    logic user_mode;
    logic base_cnt;
    logic perf_cnt;
    logic debug_sup;
  } perm_cfg_t;

  localparam logic [CSR_AW-1:0] ADDR_CNT_EN   = 12'h306;
  localparam logic [CSR_AW-1:0] ADDR_DBG_CTRL = 12'h7B0;
  localparam logic [CSR_AW-1:0] ADDR_DBG_PC   = 12'h7B1;
  localparam logic [CSR_AW-1:0] ADDR_DBG_SCR  = 12'h7B2;
  localparam logic [3:0]        CNT_PAGE      = 4'hC;

endpackage

// File: rtl/cnten_fold.sv
module cnten_fold
  import csr_perm_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int BASE_LO = 0,
  parameter int BASE_HI = 2,
  parameter int PERF_LO = 3,
  parameter int PERF_HI = 15
) (
  input  perm_cfg_t         cfg,
  input  logic [DATA_W-1:0] wdata,
  output logic              fold_bit
);

  logic base_any;
  logic perf_any;
  logic unused_fold_hi;

  assign base_any = |wdata[BASE_HI:BASE_LO];
  assign perf_any = |wdata[PERF_HI:PERF_LO];
  assign unused_fold_hi = ^wdata[DATA_W-1:PERF_HI+1];

  // Both ranges are contiguous, so with both counter types present this is an OR over BASE_LO..PERF_HI
  assign fold_bit = (cfg.base_cnt & base_any) | (cfg.perf_cnt & perf_any);

endmodule

// File: rtl/cnten_store.sv
module cnten_store
  import csr_perm_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int BASE_LO = 0,
  parameter int BASE_HI = 2,
  parameter int PERF_LO = 3,
  parameter int PERF_HI = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  perm_cfg_t         cfg,
  input  logic              wr_fire,
  input  logic              fold_bit,
  input  logic              rd_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic              en_q,
  output logic [DATA_W-1:0] rdata
);

  logic              en_d;
  logic [DATA_W-1:0] rd_img;

  always_comb begin
    en_d = en_q;
    if (!cfg.user_mode) en_d = 1'b0;
    else if (wr_fire)   en_d = fold_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_rd
    if (i >= BASE_LO && i <= BASE_HI) begin : g_base
      assign rd_img[i] = cfg.base_cnt & en_q;
    end else if (i >= PERF_LO && i <= PERF_HI) begin : g_perf
      assign rd_img[i] = cfg.perf_cnt & en_q;
    end else begin : g_zero
      assign rd_img[i] = 1'b0;
    end
  end

  assign rdata = rd_sel ? rd_img : '0;

  assert_no_user_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.user_mode |=> !en_q);

  assert_hold_without_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_fire && cfg.user_mode) |=> $stable(en_q));

  assert_full_fold_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && cfg.user_mode && cfg.base_cnt && cfg.perf_cnt && (|wdata[PERF_HI:BASE_LO])) |=> en_q);

  assert_base_replicated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel |-> (rdata[BASE_HI:BASE_LO] == '0 || rdata[BASE_HI:BASE_LO] == '1));

endmodule

// File: rtl/csr_access_judge.sv
module csr_access_judge
  import csr_perm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  perm_cfg_t         cfg,
  input  logic              dbg_active,
  input  priv_e             priv,
  input  logic [CSR_AW-1:0] addr,
  input  logic              en_bit,
  output logic              access_ok
);

  logic is_dbg_csr;
  logic is_cnt_csr;
  logic is_user;
  logic any_cnt;

  assign is_dbg_csr = (addr == ADDR_DBG_CTRL) || (addr == ADDR_DBG_PC) || (addr == ADDR_DBG_SCR);
  assign is_cnt_csr = (addr[11:8] == CNT_PAGE);
  assign is_user    = (priv == PRIV_USER);
  assign any_cnt    = cfg.base_cnt | cfg.perf_cnt;

  // Checked in priority order: debug lock, counter gate, privilege field
  always_comb begin
    access_ok = 1'b1;
    if (is_dbg_csr && cfg.debug_sup && !dbg_active)
      access_ok = 1'b0;
    else if (is_cnt_csr && any_cnt && cfg.user_mode && is_user && !en_bit)
      access_ok = 1'b0;
    else if (addr[9:8] != 2'b00 && is_user)
      access_ok = 1'b0;
  end

  assert_user_hi_space_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == PRIV_USER && addr[9:8] != 2'b00) |-> !access_ok);

  assert_dbg_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr == ADDR_DBG_CTRL || addr == ADDR_DBG_PC || addr == ADDR_DBG_SCR)
      && cfg.debug_sup && !dbg_active) |-> !access_ok);

  assert_mach_counter_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == PRIV_MACH && addr[11:8] == 4'hC) |-> access_ok);

  assert_user_counter_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (priv == PRIV_USER && addr[11:8] == 4'hC && cfg.user_mode
      && (cfg.base_cnt || cfg.perf_cnt) && !en_bit) |-> !access_ok);

endmodule

// File: rtl/csr_perm_gate.sv
module csr_perm_gate
  import csr_perm_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int BASE_LO = 0,
  parameter int BASE_HI = 2,
  parameter int PERF_LO = 3,
  parameter int PERF_HI = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_user_mode,
  input  logic              cfg_base_cnt,
  input  logic              cfg_perf_cnt,
  input  logic              cfg_debug_sup,
  input  logic              dbg_active,
  input  logic              priv_mach,
  input  logic [11:0]       csr_addr,
  input  logic              csr_wr_en,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  output logic              access_ok
);

  perm_cfg_t cfg;
  priv_e     priv;
  logic      en_q;
  logic      fold_bit;
  logic      rd_sel;
  logic      wr_fire;

  assign cfg.user_mode = cfg_user_mode;
  assign cfg.base_cnt  = cfg_base_cnt;
  assign cfg.perf_cnt  = cfg_perf_cnt;
  assign cfg.debug_sup = cfg_debug_sup;
  assign priv          = priv_mach ? PRIV_MACH : PRIV_USER;

  assign rd_sel  = (csr_addr == ADDR_CNT_EN);
  assign wr_fire = csr_wr_en & rd_sel & access_ok;

  csr_access_judge u_judge (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg        (cfg),
    .dbg_active (dbg_active),
    .priv       (priv),
    .addr       (csr_addr),
    .en_bit     (en_q),
    .access_ok  (access_ok)
  );

  cnten_fold #(
    .DATA_W (DATA_W), .BASE_LO (BASE_LO), .BASE_HI (BASE_HI),
    .PERF_LO (PERF_LO), .PERF_HI (PERF_HI)
  ) u_fold (
    .cfg      (cfg),
    .wdata    (csr_wdata),
    .fold_bit (fold_bit)
  );

  cnten_store #(
    .DATA_W (DATA_W), .BASE_LO (BASE_LO), .BASE_HI (BASE_HI),
    .PERF_LO (PERF_LO), .PERF_HI (PERF_HI)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg      (cfg),
    .wr_fire  (wr_fire),
    .fold_bit (fold_bit),
    .rd_sel   (rd_sel),
    .wdata    (csr_wdata),
    .en_q     (en_q),
    .rdata    (csr_rdata)
  );

endmodule

// File: tb/csr_perm_gate_tb_top.sv
module csr_perm_gate_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_user_mode = 1'b1, cfg_base_cnt = 1'b1, cfg_perf_cnt = 1'b1, cfg_debug_sup = 1'b1;
  logic        dbg_active = 1'b0;
  logic        priv_mach = 1'b1;
  logic [11:0] csr_addr = 12'h000;
  logic        csr_wr_en = 1'b0;
  logic [31:0] csr_wdata = 32'h0;
  logic [31:0] csr_rdata;
  logic        access_ok;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_perm_gate dut_i (
    .clk (clk), .rst_n (rst_n),
    .cfg_user_mode (cfg_user_mode), .cfg_base_cnt (cfg_base_cnt),
    .cfg_perf_cnt (cfg_perf_cnt), .cfg_debug_sup (cfg_debug_sup),
    .dbg_active (dbg_active), .priv_mach (priv_mach),
    .csr_addr (csr_addr), .csr_wr_en (csr_wr_en), .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata), .access_ok (access_ok)
  );

  // Layout: [23:20] tag, [19:16] cfg {user,base,perf,dbgsup}, [15] enable wanted,
  // [14] priv_mach, [13] dbg_active, [12] expected access_ok, [11:0] address
  localparam logic [23:0] VEC [NVEC] = '{
    {4'd6, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 12'hC00},  // R6 denied, bit clear
    {4'd6, 4'hF, 1'b1, 1'b0, 1'b0, 1'b1, 12'hC00},  // R6 allowed, bit set
    {4'd7, 4'hF, 1'b0, 1'b1, 1'b0, 1'b1, 12'hC02},  // R7 machine always
    {4'd6, 4'hF, 1'b1, 1'b0, 1'b0, 1'b1, 12'hC83},  // R6 upper-half counter
    {4'd6, 4'h9, 1'b0, 1'b0, 1'b0, 1'b1, 12'hC00},  // R6 no counter type
    {4'd9, 4'hF, 1'b0, 1'b0, 1'b0, 1'b0, 12'h300},  // R9 machine field
    {4'd9, 4'hF, 1'b1, 1'b0, 1'b0, 1'b0, 12'h100},  // R9 bits 9:8 = 01
    {4'd8, 4'hF, 1'b0, 1'b1, 1'b0, 1'b0, 12'h7B0},  // R8 locked
    {4'd8, 4'hF, 1'b0, 1'b1, 1'b1, 1'b1, 12'h7B1},  // R8 active
    {4'd8, 4'hE, 1'b0, 1'b1, 1'b0, 1'b1, 12'h7B2},  // R8 no debug support
    {4'd8, 4'hF, 1'b0, 1'b1, 1'b0, 1'b1, 12'h7B3},  // R8 neighbour address
    {4'd9, 4'hF, 1'b0, 1'b1, 1'b0, 1'b1, 12'h300},  // R9 machine allowed
    {4'd5, 4'h7, 1'b0, 1'b0, 1'b0, 1'b1, 12'hC00},  // R5 no user mode
    {4'd9, 4'hF, 1'b0, 1'b0, 1'b0, 1'b1, 12'h000}   // R9 user field 00
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic pm, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    priv_mach = pm; csr_addr = a; csr_wdata = d; csr_wr_en = 1'b1;
    @(negedge clk);
    csr_wr_en = 1'b0; priv_mach = 1'b1; csr_addr = 12'h306; csr_wdata = 32'h0;
    #1;
  endtask

  task automatic set_cfg(input logic [3:0] c);
    @(negedge clk);
    {cfg_user_mode, cfg_base_cnt, cfg_perf_cnt, cfg_debug_sup} = c;
    dbg_active = 1'b0;
  endtask

  task automatic read_en(input string tag, input logic [31:0] exp);
    @(negedge clk);
    priv_mach = 1'b1; csr_addr = 12'h306;
    #1;
    chk(tag, csr_rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    read_en("R1 reset read", 32'h0);

    // Vector table walk
    for (int v = 0; v < NVEC; v++) begin
      set_cfg(VEC[v][19:16]);
      do_write(1'b1, 12'h306, VEC[v][15] ? 32'h0000_FFFF : 32'h0);
      @(negedge clk);
      priv_mach = VEC[v][14]; dbg_active = VEC[v][13]; csr_addr = VEC[v][11:0];
      #1;
      n_chk++;
      if (access_ok !== VEC[v][12]) begin
        n_bad++;
        $display("FAIL vector %0d R%0d actual=%b expected=%b", v, VEC[v][23:20], access_ok, VEC[v][12]);
      end
    end

    // R2 full fold
    set_cfg(4'hF);
    do_write(1'b1, 12'h306, 32'h0);
    do_write(1'b1, 12'h306, 32'h0001_0000);
    read_en("R2 bit16 ignored", 32'h0);
    do_write(1'b1, 12'h306, 32'h0000_8000);
    read_en("R2 bit15 sets all", 32'h0000_FFFF);
    do_write(1'b1, 12'h306, 32'h0000_0001);
    read_en("R2 bit0 sets all", 32'h0000_FFFF);

    // R4 other address reads zero
    @(negedge clk); csr_addr = 12'h305; #1;
    chk("R4 other address", csr_rdata, 32'h0);

    // R10 denied user write and write to other address
    do_write(1'b0, 12'h306, 32'h0);
    read_en("R10 denied write held", 32'h0000_FFFF);
    do_write(1'b1, 12'h305, 32'h0);
    read_en("R10 other address held", 32'h0000_FFFF);

    // R3 base only
    set_cfg(4'hC);
    do_write(1'b1, 12'h306, 32'h0);
    do_write(1'b1, 12'h306, 32'h0000_0008);
    read_en("R3 base ignores bit3", 32'h0);
    do_write(1'b1, 12'h306, 32'h0000_0004);
    read_en("R3 R4 base image", 32'h0000_0007);

    // R3 perf only
    set_cfg(4'hA);
    do_write(1'b1, 12'h306, 32'h0);
    do_write(1'b1, 12'h306, 32'h0000_0004);
    read_en("R3 perf ignores bit2", 32'h0);
    do_write(1'b1, 12'h306, 32'h0000_0008);
    read_en("R3 R4 perf image", 32'h0000_FFF8);

    // R5 no user mode
    set_cfg(4'h7);
    do_write(1'b1, 12'h306, 32'h0000_FFFF);
    read_en("R5 hardwired zero", 32'h0);
    chk("R5 machine access ok", {31'h0, access_ok}, 32'h1);

    // R1 reset clears a set bit
    set_cfg(4'hF);
    do_write(1'b1, 12'h306, 32'h0000_0002);
    read_en("R1 preset", 32'h0000_FFFF);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    read_en("R1 after reset", 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule